// File: doc/BRIEF.md
# PWM Period and High-Time Meter

This block times a pulse-width-modulated input against the system clock. One counter is restarted by every rising edge of the synchronized input. The value it holds at a rising edge is the period, and the value it holds at a falling edge is the high time. Each capture reads the number of clocks since the last rising edge. The counter stops at its all-ones value and does not wrap, so a reading of all ones means the interval was too long to measure.

A start strobe together with a mode code selects one of three operating modes:

- **Idle** stops the counter and ignores the input.
- **Continuous** keeps the most recent complete period and high time as a matched pair.
- **Burst** discards the partial cycle that is in progress when the mode is entered. It then sums a programmed number of whole cycles into wide accumulators and stops by itself. When it stops it raises a one-clock done flag and falls back to idle. The sums and the cycle count stay visible until the next burst begins.

Top module: `pwm_meas`

## Requirements
- R1: The input passes through a two-stage synchronizer and a previous-sample compare. A capture taken on an edge equals the number of clocks since the preceding rising edge. A waveform that repeats every P clocks and is high for H clocks therefore reads period P and high time H.
- R2: In continuous mode (mode code 1), every rising edge updates `period_q` and `high_q` together. They carry the period just completed and the high time captured within that same cycle.
- R3: Entering continuous mode from another mode clears `period_q`, `high_q` and the pending high time, and restarts the counter from zero.
- R4: The counter stops at all ones when no rising edge arrives. A period or high time longer than 2^CNT_W-1 clocks reads as all ones.
- R5: Entering burst mode (mode code 2) clears both accumulators, the cycle count and the pending high time. The first rising edge after entry only ends the partial cycle and adds nothing.
- R6: In burst mode, every later rising edge adds the period to `period_acc` and the latest high time to `high_acc`, and increments `cycle_cnt`. With a target N (1 to 2^NCYC_W-1), the results are N·P, N·H and N.
- R7: On the rising edge that makes `cycle_cnt` equal to the target, the counter stops and the block enters the busy state (mode code 3). `done` is high for exactly that one clock, and the mode then returns to idle (code 0).
- R8: After a burst completes or is aborted, the accumulators and `cycle_cnt` hold their values until the next burst starts, whatever the input does in the meantime.
- R9: In idle mode, input edges are discarded. `period_q` and `high_q` keep their last values.
- R10: A start request naming the mode that is already active has no effect. Values are not cleared and a running burst is not restarted.
- R11: A start request with mode code 3 is ignored. A request for idle during a burst aborts it with no done pulse.
- R12: `mode_q` reports the active mode as 0 idle, 1 continuous, 2 burst, 3 busy, and reads 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | Asynchronous PWM input |
| mode_sel | input | 2 | Requested mode code, taken when `start` is high |
| start | input | 1 | One-clock mode change request |
| target | input | NCYC_W | Number of cycles to accumulate in burst mode |
| period_q | output | CNT_W | Last published period (continuous) |
| high_q | output | CNT_W | High time paired with `period_q` |
| period_acc | output | ACC_W | Burst sum of periods |
| high_acc | output | ACC_W | Burst sum of high times |
| cycle_cnt | output | NCYC_W | Cycles accumulated in the current or last burst |
| done | output | 1 | One-clock pulse when a burst reaches its target |
| mode_q | output | 2 | Active mode code |

## Verification
Continuous mode is swept over every high time for each period in a small range. A pairing mistake, an off-by-one count or swapped captures would each show up as a specific wrong (P, H) reading. Deliberately long intervals separate saturation from wrap-around.

Burst mode is run for every target from one upward with distinct periods and high times. A missing skip of the partial cycle shows up as an extra cycle's worth in the sums. A wrong stop point shows up as a count other than N. The input keeps toggling after completion and after an abort, which shows whether the held results and the idle discard are respected.

// File: rtl/pwm_meas_pkg.sv
package pwm_meas_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_CONT  = 2'd1,
    MODE_BURST = 2'd2,
    MODE_BUSY  = 2'd3
  } meas_mode_e;
endpackage

// File: rtl/pwm_meas_edge.sv
module pwm_meas_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  localparam int LAST = SYNC_STAGES;

  logic [LAST:0] shreg_q;
  logic [LAST:0] shreg_d;

  always_comb begin
    shreg_d = {shreg_q[LAST-1:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg_q <= '0;
    else        shreg_q <= shreg_d;
  end

  // level is the synchronized sample, compared with the one before it
  always_comb begin
    rise = shreg_q[LAST-1] & ~shreg_q[LAST];
    fall = ~shreg_q[LAST-1] & shreg_q[LAST];
  end
endmodule

// File: rtl/pwm_meas_timer.sv
module pwm_meas_timer #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic             restart,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clear | run;
    cnt_d  = cnt;
    if (clear)                cnt_d = '0;
    else if (restart)         cnt_d = CNT_ONE;
    else if (cnt != CNT_MAX)  cnt_d = cnt + CNT_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end

  p_sat_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clear && !restart && cnt == CNT_MAX) |=> cnt == CNT_MAX);
  p_restart_one_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && restart && !clear) |=> cnt == CNT_ONE);
endmodule

// File: rtl/pwm_meas_accum.sv
module pwm_meas_accum #(
  parameter int CNT_W  = 32,
  parameter int ACC_W  = 64,
  parameter int NCYC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              en,
  input  logic              rise_ev,
  input  logic [CNT_W-1:0]  period,
  input  logic [CNT_W-1:0]  high,
  input  logic [NCYC_W-1:0] target,
  output logic [ACC_W-1:0]  acc_p,
  output logic [ACC_W-1:0]  acc_h,
  output logic [NCYC_W-1:0] ncyc,
  output logic              hit
);
  localparam int PAD_W = ACC_W - CNT_W;

  logic              skip_q, skip_d;
  logic [ACC_W-1:0]  acc_p_d, acc_h_d;
  logic [NCYC_W-1:0] ncyc_d, ncyc_inc;
  logic              take;
  logic              upd_en;

  always_comb begin
    ncyc_inc = ncyc + NCYC_W'(1);
    take     = en && rise_ev && !skip_q;
    hit      = take && (ncyc_inc == target);
    upd_en   = clear | (en & rise_ev);
    skip_d   = skip_q;
    acc_p_d  = acc_p;
    acc_h_d  = acc_h;
    ncyc_d   = ncyc;
    if (clear) begin
      skip_d  = 1'b1;
      acc_p_d = '0;
      acc_h_d = '0;
      ncyc_d  = '0;
    end else if (skip_q) begin
      skip_d = 1'b0;
    end else begin
      acc_p_d = acc_p + {{PAD_W{1'b0}}, period};
      acc_h_d = acc_h + {{PAD_W{1'b0}}, high};
      ncyc_d  = ncyc_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      skip_q <= 1'b0;
      acc_p  <= '0;
      acc_h  <= '0;
      ncyc   <= '0;
    end else if (upd_en) begin
      skip_q <= skip_d;
      acc_p  <= acc_p_d;
      acc_h  <= acc_h_d;
      ncyc   <= ncyc_d;
    end
  end

  p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (ncyc == '0 && acc_p == '0 && acc_h == '0));
  p_hold_results_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clear) |=> ($stable(acc_p) && $stable(acc_h) && $stable(ncyc)));
endmodule

// File: rtl/pwm_meas.sv
module pwm_meas #(
  parameter int CNT_W       = 32,
  parameter int ACC_W       = 64,
  parameter int NCYC_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwm_in,
  input  logic [1:0]        mode_sel,
  input  logic              start,
  input  logic [NCYC_W-1:0] target,
  output logic [CNT_W-1:0]  period_q,
  output logic [CNT_W-1:0]  high_q,
  output logic [ACC_W-1:0]  period_acc,
  output logic [ACC_W-1:0]  high_acc,
  output logic [NCYC_W-1:0] cycle_cnt,
  output logic              done,
  output logic [1:0]        mode_q
);
  import pwm_meas_pkg::*;

  meas_mode_e       mode_r, mode_d, req_mode;
  logic             rise, fall, rise_g, fall_g;
  logic             running, req_ok;
  logic             enter_cont, enter_burst, go_idle, burst_hit;
  logic             tmr_clear, tmr_run;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] hi_pend_q, hi_pend_d;
  logic [CNT_W-1:0] period_d, high_d;
  logic             pend_en, pub_en;

  pwm_meas_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .din(pwm_in), .rise(rise), .fall(fall)
  );

  always_comb begin
    req_mode    = meas_mode_e'(mode_sel);
    running     = (mode_r == MODE_CONT) || (mode_r == MODE_BURST);
    rise_g      = rise & running;
    fall_g      = fall & running;
    req_ok      = start && (req_mode != MODE_BUSY) && (req_mode != mode_r)
                  && (mode_r != MODE_BUSY);
    enter_cont  = req_ok && (req_mode == MODE_CONT);
    enter_burst = req_ok && (req_mode == MODE_BURST);
    go_idle     = req_ok && (req_mode == MODE_IDLE);
    tmr_clear   = enter_cont | enter_burst | go_idle | burst_hit;
    tmr_run     = running;
  end

  pwm_meas_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(tmr_clear), .run(tmr_run),
    .restart(rise_g), .cnt(cnt)
  );

  pwm_meas_accum #(.CNT_W(CNT_W), .ACC_W(ACC_W), .NCYC_W(NCYC_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .clear(enter_burst),
    .en(mode_r == MODE_BURST), .rise_ev(rise_g), .period(cnt),
    .high(hi_pend_q), .target(target), .acc_p(period_acc),
    .acc_h(high_acc), .ncyc(cycle_cnt), .hit(burst_hit)
  );

  // mode sequencing: a request overrides a completion in the same clock
  always_comb begin
    mode_d = mode_r;
    if (mode_r == MODE_BUSY)                        mode_d = MODE_IDLE;
    else if (burst_hit && mode_r == MODE_BURST)     mode_d = MODE_BUSY;
    if (req_ok)                                     mode_d = req_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_r <= MODE_IDLE;
    else        mode_r <= mode_d;
  end

  // pending high time and continuous publish
  always_comb begin
    pend_en   = enter_cont | enter_burst | fall_g;
    hi_pend_d = (enter_cont | enter_burst) ? '0 : cnt;
    pub_en    = enter_cont | (rise_g & (mode_r == MODE_CONT));
    period_d  = enter_cont ? '0 : cnt;
    high_d    = enter_cont ? '0 : hi_pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hi_pend_q <= '0;
    else if (pend_en) hi_pend_q <= hi_pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
      high_q   <= '0;
    end else if (pub_en) begin
      period_q <= period_d;
      high_q   <= high_d;
    end
  end

  always_comb begin
    done   = (mode_r == MODE_BUSY);
    mode_q = mode_r;
  end

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && mode_q == 2'd0));
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd0 && !start) |=> ($stable(period_q) && $stable(high_q)));
  p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (start && mode_sel == 2'd3 && mode_q != 2'd3) |=> $stable(mode_q));
endmodule

// File: tb/pwm_meas_test.sv
module pwm_meas_test;
  localparam int CNT_W  = 8;
  localparam int ACC_W  = 16;
  localparam int NCYC_W = 4;
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              pwm_in = 1'b0;
  logic [1:0]        mode_sel = 2'd0;
  logic              start = 1'b0;
  logic [NCYC_W-1:0] target = '0;
  logic [CNT_W-1:0]  period_q, high_q;
  logic [ACC_W-1:0]  period_acc, high_acc;
  logic [NCYC_W-1:0] cycle_cnt;
  logic              done;
  logic [1:0]        mode_q;

  int checks = 0;
  int failures = 0;
  int done_seen = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pwm_meas #(.CNT_W(CNT_W), .ACC_W(ACC_W), .NCYC_W(NCYC_W), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .mode_sel(mode_sel),
    .start(start), .target(target), .period_q(period_q), .high_q(high_q),
    .period_acc(period_acc), .high_acc(high_acc), .cycle_cnt(cycle_cnt),
    .done(done), .mode_q(mode_q)
  );

  always @(posedge clk) if (rst_n && done) done_seen <= done_seen + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_clocks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic request(input logic [1:0] m);
    @(negedge clk);
    mode_sel = m;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic pwm_cycles(input int p, input int h, input int n);
    for (int c = 0; c < n; c++) begin
      for (int t = 0; t < p; t++) begin
        @(negedge clk);
        pwm_in = (t < h);
      end
    end
    @(negedge clk);
    pwm_in = 1'b0;
  endtask

  initial begin
    #600000;
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle_clocks(3);
    rst_n = 1'b1;
    idle_clocks(2);
    // R12 reset state
    chk(mode_q == 2'd0, "R12 reset mode", mode_q, 0);
    chk(period_q == 0 && high_q == 0, "R12 reset captures", period_q, 0);
    chk(done == 1'b0 && cycle_cnt == 0, "R12 reset done/count", done, 0);

    // R9 idle discards edges
    pwm_cycles(6, 3, 4);
    idle_clocks(4);
    chk(period_q == 0, "R9 idle period", period_q, 0);
    chk(high_q == 0, "R9 idle high", high_q, 0);

    // R1 R2 continuous sweep
    request(2'd1);
    chk(mode_q == 2'd1, "R12 cont mode", mode_q, 1);
    for (int p = 4; p <= 11; p++) begin
      for (int h = 1; h < p; h++) begin
        pwm_cycles(p, h, 3);
        chk(period_q == p, "R1 period", period_q, p);
        chk(high_q == h, "R2 paired high", high_q, h);
      end
    end

    // R10 same-mode request keeps values
    request(2'd1);
    idle_clocks(3);
    chk(period_q == 11 && high_q == 10, "R10 cont re-request", period_q, 11);

    // R4 saturation
    pwm_cycles(300, 5, 1);
    pwm_cycles(6, 2, 1);
    chk(period_q == CMAX, "R4 period saturates", period_q, CMAX);
    chk(high_q == 5, "R4 short high beside long period", high_q, 5);
    pwm_cycles(600, 400, 1);
    pwm_cycles(6, 2, 1);
    chk(high_q == CMAX, "R4 high saturates", high_q, CMAX);

    // R9 idle holds published values
    request(2'd0);
    pwm_cycles(7, 3, 3);
    idle_clocks(4);
    chk(period_q == CMAX && high_q == CMAX, "R9 idle holds", period_q, CMAX);

    // R3 re-entering continuous clears
    request(2'd1);
    idle_clocks(1);
    chk(period_q == 0 && high_q == 0, "R3 cont entry clears", period_q, 0);

    // R11 busy code ignored
    request(2'd3);
    chk(mode_q == 2'd1, "R11 code 3 ignored", mode_q, 1);
    request(2'd0);

    // R5 R6 R7 R8 bursts
    for (int n = 1; n <= 6; n++) begin
      int p, h, d0;
      p = 4 + n;
      h = 1 + (n % 3);
      target = NCYC_W'(n);
      d0 = done_seen;
      request(2'd2);
      chk(cycle_cnt == 0 && period_acc == 0 && high_acc == 0, "R5 burst entry clears",
          cycle_cnt, 0);
      pwm_cycles(p, h, n + 2);
      idle_clocks(4);
      chk(done_seen - d0 == 1, "R7 one done pulse", done_seen - d0, 1);
      chk(mode_q == 2'd0, "R7 back to idle", mode_q, 0);
      chk(cycle_cnt == n, "R6 cycle count", cycle_cnt, n);
      chk(period_acc == n * p, "R5 R6 period sum", period_acc, n * p);
      chk(high_acc == n * h, "R6 high sum", high_acc, n * h);
      pwm_cycles(5, 2, 3);
      idle_clocks(4);
      chk(period_acc == n * p && high_acc == n * h && cycle_cnt == n,
          "R8 results held", period_acc, n * p);
    end

    // R10 burst re-request does not restart; R11 abort
    target = NCYC_W'(10);
    request(2'd2);
    pwm_cycles(6, 2, 4);
    idle_clocks(4);
    chk(cycle_cnt == 3, "R6 partial count", cycle_cnt, 3);
    request(2'd2);
    idle_clocks(1);
    chk(cycle_cnt == 3 && period_acc == 18, "R10 burst re-request", cycle_cnt, 3);
    begin
      int d1;
      d1 = done_seen;
      request(2'd0);
      pwm_cycles(6, 2, 4);
      idle_clocks(4);
      chk(done_seen == d1, "R11 abort no done", done_seen - d1, 0);
      chk(mode_q == 2'd0, "R11 abort idle", mode_q, 0);
      chk(cycle_cnt == 3 && period_acc == 18 && high_acc == 6, "R8 abort holds",
          period_acc, 18);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule